// File: doc/BRIEF.md
# DRAM Rank Boundary Decoder

This block turns a physical address into a DRAM target: the channel, the rank within that channel, and the byte offset inside that rank. It holds eight boundary registers, four per channel. Each register stores a cumulative upper bound in 64 MB units, so the register for rank N holds the total size of ranks 0 through N of its channel. Software loads the registers through a plain write port (address, data, enable). A lock input freezes them against further writes, and a combinational read port returns their contents.

Two map layouts are supported. In non-stacked mode each channel is decoded on its own, and an upstream channel select picks which register set applies. In stacked mode, channel 1 sits directly above channel 0 in one linear map. Channel 1 registers then hold absolute bounds that start at the channel 0 total, and every unpopulated rank repeats the top boundary. The decode result is registered, so it appears one clock after the address is presented.

Top module: `rank_bound_dec`

## Requirements
- R1: After reset every boundary register reads zero, and dec_vld, dec_miss, dec_ch, dec_rank and dec_offs are all zero.
- R2: A write with wr_en=1 and lock=0 stores wr_data[9:0] into the register selected by wr_addr. Register address encoding: bit 2 is the channel and bits 1:0 are the rank. rd_data returns the register selected by rd_addr (same encoding) in the same cycle.
- R3: rd_data[15:10] always reads zero, whatever was written to those bits.
- R4: While lock=1, writes are ignored and every register keeps its value.
- R5: The decode outputs reflect the inputs sampled at the clock edge where addr_vld=1. dec_vld equals addr_vld delayed by one cycle.
- R6: In non-stacked mode (stacked=0), the channel is ch_sel. The rank is the lowest N for which lo(N) <= idx < B[N]. Here idx = phys_addr[35:26], B[N] is that channel's register for rank N, lo(0)=0, and lo(N)=B[N-1].
- R7: On a hit, dec_offs = phys_addr minus lo(rank) x 64 MB.
- R8: In stacked mode (stacked=1), ch_sel is ignored. Channel 0 is searched first with lo(0)=0. Otherwise channel 1 is searched against its absolute bounds, with lo(0) equal to the channel 0 rank-3 register.
- R9: An address that matches no rank gives dec_miss=1, with dec_ch=0, dec_rank=0 and dec_offs=0. This covers any idx at or above the final bound.
- R10: A rank whose bound equals the bound below it has zero size and is never reported.
- R11: A channel whose four registers are all zero never decodes a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for writes: {channel, rank} |
| wr_data | input | 16 | Write data; bits 9:0 are stored |
| lock | input | 1 | Freezes the boundary registers |
| rd_addr | input | 3 | Register select for reads: {channel, rank} |
| rd_data | output | 16 | Selected register, upper six bits zero |
| stacked | input | 1 | 1: channel 1 placed above channel 0 |
| ch_sel | input | 1 | Channel to decode in non-stacked mode |
| addr_vld | input | 1 | Physical address is valid this cycle |
| phys_addr | input | 36 | Physical byte address |
| dec_vld | output | 1 | Decode result valid |
| dec_miss | output | 1 | Address falls in no rank |
| dec_ch | output | 1 | Decoded channel |
| dec_rank | output | 2 | Decoded rank |
| dec_offs | output | 36 | Byte offset within the decoded rank |

## Verification
A corrupted boundary register shows at the ports in two ways: rd_data reads back the wrong value at once, and an address near that bound decodes one cycle later to a neighbouring rank, to the wrong offset, or as a miss. A wrong choice of lower bound shows up in dec_offs even when the rank is correct. The bench therefore probes addresses just below and exactly at every programmed bound. A write that slips through the lock appears as a changed read-back on the very next cycle.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  localparam int NCH    = 2;
  localparam int NRANK  = 4;
  localparam int BND_W  = 10;
  localparam int REG_W  = 16;
  localparam int NREG   = NCH * NRANK;
  localparam int RAD_W  = $clog2(NREG);
  localparam int RANK_W = $clog2(NRANK);
  typedef logic [BND_W-1:0]  bnd_t;
  typedef logic [RANK_W-1:0] rank_t;
endpackage

// File: rtl/rbd_regfile.sv
module rbd_regfile
  import rbd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [RAD_W-1:0]       wr_addr,
  input  logic [REG_W-1:0]       wr_data,
  input  logic                   lock,
  input  logic [RAD_W-1:0]       rd_addr,
  output logic [REG_W-1:0]       rd_data,
  output logic [NREG*BND_W-1:0]  bnd_flat
);
  bnd_t bnd_q [NREG];
  logic wr_fire;
  logic unused_rsvd;

  assign wr_fire     = wr_en && !lock;
  assign unused_rsvd = ^wr_data[REG_W-1:BND_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bnd_q[i] <= '0;
    end else if (wr_fire) begin
      bnd_q[wr_addr] <= wr_data[BND_W-1:0];
    end
  end

  assign rd_data = {{(REG_W-BND_W){1'b0}}, bnd_q[rd_addr]};

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign bnd_flat[g*BND_W +: BND_W] = bnd_q[g];
  end

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(bnd_flat)); // R4
  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (bnd_q[$past(wr_addr)] == $past(wr_data[BND_W-1:0]))); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:BND_W] == '0); // R3
endmodule

// File: rtl/rbd_chan_lookup.sv
module rbd_chan_lookup
  import rbd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  bnd_t                   idx,
  input  bnd_t                   base,
  input  logic [NRANK*BND_W-1:0] bnd,
  output logic                   hit,
  output rank_t                  rank,
  output bnd_t                   low
);
  function automatic logic in_window(bnd_t v, bnd_t lo, bnd_t hi);
    return (v >= lo) && (v < hi);
  endfunction

  logic  chan_empty;
  bnd_t  lo_n;
  assign chan_empty = (bnd == '0);

  always_comb begin
    hit  = 1'b0;
    rank = '0;
    low  = '0;
    lo_n = '0;
    for (int n = 0; n < NRANK; n++) begin
      lo_n = (n == 0) ? base : bnd[(n-1)*BND_W +: BND_W];
      if (!hit && in_window(idx, lo_n, bnd[n*BND_W +: BND_W])) begin
        hit  = 1'b1;
        rank = rank_t'(n);
        low  = lo_n;
      end
    end
  end

  AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    chan_empty |-> !hit); // R11
  AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (idx >= low) && (idx < bnd[rank*BND_W +: BND_W])); // R6
endmodule

// File: rtl/rank_bound_dec.sv
module rank_bound_dec
  import rbd_pkg::*;
#(
  parameter int ADDR_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              lock,
  input  logic [2:0]        rd_addr,
  output logic [15:0]       rd_data,
  input  logic              stacked,
  input  logic              ch_sel,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] phys_addr,
  output logic              dec_vld,
  output logic              dec_miss,
  output logic              dec_ch,
  output logic [1:0]        dec_rank,
  output logic [ADDR_W-1:0] dec_offs
);
  localparam int UNIT_LSB = ADDR_W - BND_W;
  localparam int CH_BITS  = NRANK * BND_W;

  function automatic logic [ADDR_W-1:0] rank_offset(logic [ADDR_W-1:0] a, bnd_t lo);
    return a - ({{(ADDR_W-BND_W){1'b0}}, lo} << UNIT_LSB);
  endfunction

  logic [NREG*BND_W-1:0] bnd_flat;
  bnd_t  idx;
  bnd_t  base   [NCH];
  logic  hit    [NCH];
  rank_t rank   [NCH];
  bnd_t  low    [NCH];

  rbd_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lock(lock), .rd_addr(rd_addr),
    .rd_data(rd_data), .bnd_flat(bnd_flat)
  );

  assign idx     = phys_addr[ADDR_W-1:UNIT_LSB];
  assign base[0] = '0;
  assign base[1] = stacked ? bnd_flat[CH_BITS-BND_W +: BND_W] : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    rbd_chan_lookup u_look (
      .clk(clk), .rst_n(rst_n), .idx(idx), .base(base[c]),
      .bnd(bnd_flat[c*CH_BITS +: CH_BITS]),
      .hit(hit[c]), .rank(rank[c]), .low(low[c])
    );
  end

  logic  sel_hit, sel_ch;
  rank_t sel_rank;
  bnd_t  sel_low;

  always_comb begin
    sel_hit  = 1'b0;
    sel_ch   = 1'b0;
    sel_rank = '0;
    sel_low  = '0;
    if (stacked) begin
      if (hit[0]) begin
        sel_hit = 1'b1; sel_ch = 1'b0; sel_rank = rank[0]; sel_low = low[0];
      end else if (hit[1]) begin
        sel_hit = 1'b1; sel_ch = 1'b1; sel_rank = rank[1]; sel_low = low[1];
      end
    end else if (hit[ch_sel]) begin
      sel_hit = 1'b1; sel_ch = ch_sel; sel_rank = rank[ch_sel]; sel_low = low[ch_sel];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_vld  <= 1'b0;
      dec_miss <= 1'b0;
      dec_ch   <= 1'b0;
      dec_rank <= '0;
      dec_offs <= '0;
    end else begin
      dec_vld <= addr_vld;
      if (addr_vld) begin
        dec_miss <= !sel_hit;
        dec_ch   <= sel_hit ? sel_ch : 1'b0;
        dec_rank <= sel_hit ? sel_rank : '0;
        dec_offs <= sel_hit ? rank_offset(phys_addr, sel_low) : '0;
      end
    end
  end

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dec_miss |-> (!dec_ch && dec_rank == '0 && dec_offs == '0)); // R9
  AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |=> dec_vld); // R5
  AST_VLD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> !dec_vld); // R5
  AST_STACK_CH0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && stacked && hit[0]) |=> (!dec_ch && !dec_miss)); // R8
endmodule

// File: tb/test_rank_bound_dec.sv
`timescale 1ns/1ps
module test_rank_bound_dec;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, lock = 0, stacked = 0, ch_sel = 0, addr_vld = 0;
  logic [2:0]  wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic [35:0] phys_addr = 0, dec_offs;
  logic        dec_vld, dec_miss, dec_ch;
  logic [1:0]  dec_rank;
  int n_chk = 0, n_err = 0;
  logic [9:0]  m [8];

  always #2 clk = ~clk;

  rank_bound_dec i_rank_bound_dec (.*);

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (!lock) m[a] = d[9:0];
  endtask

  task automatic load(logic [9:0] c0 [4], logic [9:0] c1 [4]);
    for (int i = 0; i < 4; i++) begin
      wr(3'(i), {6'h2a, c0[i]});
      wr(3'(4 + i), {6'h15, c1[i]});
    end
  endtask

  // Model from R6..R11: walk candidate channels in order, first window wins.
  function automatic logic [39:0] expect_dec(logic [35:0] a, logic stk, logic cs);
    logic [9:0] ix = a[35:26];
    logic [9:0] lo;
    int first = stk ? 0 : int'(cs);
    int last  = stk ? 1 : int'(cs);
    for (int c = first; c <= last; c++) begin
      for (int r = 0; r < 4; r++) begin
        if (r == 0) lo = (stk && c == 1) ? m[3] : 10'd0;
        else        lo = m[c*4 + r - 1];
        if (ix >= lo && ix < m[c*4 + r])
          return {1'b0, 1'(c), 2'(r), a - (36'(lo) << 26)};
      end
    end
    return {1'b1, 1'b0, 2'b0, 36'd0};
  endfunction

  task automatic dec(logic [35:0] a, logic stk, logic cs, string req);
    logic [39:0] e;
    @(negedge clk);
    addr_vld = 1; phys_addr = a; stacked = stk; ch_sel = cs;
    e = expect_dec(a, stk, cs);
    @(negedge clk);
    addr_vld = 0;
    phys_addr = {$urandom, $urandom};
    chk({req, " decode"}, {dec_vld, dec_miss, dec_ch, dec_rank, dec_offs}, {1'b1, e});
  endtask

  task automatic sweep(logic stk, logic cs, int n, string req);
    int top;
    top = 0;
    for (int i = 0; i < 8; i++) if (int'(m[i]) > top) top = int'(m[i]);
    for (int k = 0; k < 8; k++) begin
      dec({m[k], 26'd0}, stk, cs, req);
      dec({m[k], 26'd0} - 36'd1, stk, cs, req);
    end
    for (int i = 0; i < n; i++)
      dec({10'($urandom % (top + 3)), 26'($urandom)}, stk, cs, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [9:0] a0 [4], a1 [4], z [4];
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 8; i++) m[i] = 0;
    z = '{10'd0, 10'd0, 10'd0, 10'd0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 outputs", {dec_vld, dec_miss, dec_ch, dec_rank, dec_offs}, 0);
    for (int i = 0; i < 8; i++) begin
      rd_addr = 3'(i); #0.5;
      chk("R1 regs", rd_data, 0);
    end
    // R2 / R3 write and read-back, reserved bits zero
    wr(3'd5, 16'hffff);
    rd_addr = 3'd5; #0.5;
    chk("R2 R3 readback", rd_data, 16'h03ff);
    // R6 R7 R10 non-stacked, rank 2 of ch0 zero size
    a0 = '{10'd4, 10'd8, 10'd8, 10'd12};
    a1 = '{10'd3, 10'd7, 10'd10, 10'd16};
    load(a0, a1);
    for (int i = 0; i < 8; i++) begin
      rd_addr = 3'(i); #0.5;
      chk("R2 readback", rd_data, {6'd0, m[i]});
    end
    sweep(1'b0, 1'b0, 60, "R6 R7 R10 ns-ch0");
    sweep(1'b0, 1'b1, 60, "R6 R7 R9 ns-ch1");
    // R8 ch_sel ignored in stacked; upper ranks repeat top (R10)
    a1 = '{10'd16, 10'd20, 10'd20, 10'd20};
    load(a0, a1);
    sweep(1'b1, 1'b0, 60, "R8 R10 stacked");
    sweep(1'b1, 1'b1, 40, "R8 stacked chsel");
    dec({10'd11, 26'h123}, 1'b1, 1'b1, "R8 ch0 first");
    dec({10'd20, 26'd0}, 1'b1, 1'b0, "R9 at top");
    // R4 lock: writes ignored, map unchanged
    lock = 1;
    wr(3'd0, 16'd1);
    wr(3'd7, 16'd900);
    rd_addr = 3'd0; #0.5;
    chk("R4 lock rank0", rd_data, 16'd4);
    rd_addr = 3'd7; #0.5;
    chk("R4 lock rank7", rd_data, 16'd20);
    dec({10'd2, 26'd0}, 1'b1, 1'b0, "R4 lock decode");
    lock = 0;
    // R11 empty channel 1 and empty channel 0
    load(a0, z);
    sweep(1'b0, 1'b1, 30, "R11 ch1 empty");
    a1 = '{10'd5, 10'd9, 10'd9, 10'd9};
    load(z, a1);
    sweep(1'b1, 1'b0, 30, "R11 R8 ch0 empty stacked");
    sweep(1'b0, 1'b0, 20, "R11 ch0 empty ns");
    // R5 dec_vld drops one cycle after addr_vld drops
    @(negedge clk);
    chk("R5 vld low", dec_vld, 0);
    // random programs
    for (int t = 0; t < 6; t++) begin
      logic [9:0] acc;
      acc = 0;
      for (int i = 0; i < 4; i++) begin acc = acc + 10'($urandom % 5); a0[i] = acc; end
      for (int i = 0; i < 4; i++) begin acc = acc + 10'($urandom % 5); a1[i] = acc; end
      load(a0, a1);
      sweep(1'(t), 1'($urandom), 40, "R6 R7 R8 random");
    end
    summary();
  end
endmodule